// File: doc/BRIEF.md
# Configuration Space Register Access Unit

This block is the register-file front end of a bridge's configuration space. A host issues one read or write per cycle through a simple request port. Each request carries a device number, a byte offset of up to 4 KiB, an access size (byte, word or dword), a flag marking the memory-mapped path and a flag selecting the configuration-address pointer register. One clock later the unit answers with a valid strobe, read data and an error flag.

Two logical register sets sit behind one decoder. Device 0 is the host-bridge set and device 1 is the bridge-to-link set. Device numbers 2 and 3 are unpopulated. Byte lanes are steered little-endian, and the allowed access size is checked per region. Unpopulated locations complete quietly. Each register bit is writable, read-only or reserved according to fixed masks, and some reset defaults are loaded from strap pins while reset is held.

Top module: `cfg_space_unit`

## Requirements
- R1: Every request cycle (req_valid high) produces rsp_valid high exactly one clock later, and only then. rsp_valid is low during and right after reset. A write that is not refused returns rsp_rdata of zero.
- R2: Size encoding is 0 = byte, 1 = word, 2 = dword. Offsets below 256 accept all three sizes on either path. Read data is right-justified and little-endian: the byte at offset o is bits [8*(o mod 4)+7 : 8*(o mod 4)] of the dword at o with its two low bits cleared.
- R3: A word access with offset bit 0 set, a dword access with offset bits 1:0 nonzero, or size code 3 is refused.
- R4: Offsets 256 to 4095 accept only dword accesses with req_mmio high. Any other access there is refused.
- R5: A refused access returns rsp_rdata of 32'hFFFFFFFF with rsp_err high for that one response cycle, and changes no register.
- R6: With req_ptr high, offset and device are ignored and only dword accesses are accepted. A narrower access is refused and leaves the pointer unchanged. Only pointer bits 31 and 23:2 (mask 32'h80FFFFFC) are writable, the rest read zero, and the reset value is zero.
- R7: Device numbers 2 and 3, and every offset outside the map of R8, are reserved. Any permitted access there completes without error, reads zero and changes nothing.
- R8: The register map for devices 0 and 1, given as offset, writable mask, defined mask and default: 0x00 ID, read-only, all bits defined, 32'hA5C03C3C plus the device number in bit 16. 0x04 control, 32'h0000FFFF, 32'h00FFFFFF, see R10. 0x08 scratch, all writable, zero. 0x0C mixed, 32'h0F0F0F0F, 32'h3F3F3F3F, 32'h10101010. 0x100 extended, 32'hFFFFFF00, all defined, see R10. A write changes only bits that are writable and inside the addressed byte lanes.
- R9: Bits outside a register's defined mask always read as zero.
- R10: Reset restores every default. Device 0 control gets strap bits 7:0 in bits 23:16 and device 0 extended gets strap bits 15:8 in bits 7:0. Device 1 control resets to 32'h00110000 and device 1 extended to 32'h000000AB.
- R11: Device 0 and device 1 hold separate register contents, and writes to one never alter the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset |
| strap_i | input | 16 | Strap pins sampled while reset is held |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mmio | input | 1 | Request arrives through the memory-mapped path |
| req_ptr | input | 1 | Request targets the configuration-address pointer |
| req_dev | input | 2 | Device number |
| req_addr | input | 12 | Byte offset in the device's space |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Right-justified read data |
| rsp_err | output | 1 | Access was refused |

## Verification
Refusing an access and writing a register can fall in the same cycle. An errored write, for example a misaligned word to scratch, a narrow pointer write or a non-memory-mapped write to the extended register, must return the all-ones error response and must also leave the target untouched. The bench provokes this case directly and then reads the target back through the normal port. Lane steering and write masking also coincide on every partial write. A sweep of byte and word writes over every offset is judged by full readback against a model built from the map.

// File: rtl/cfgsu_pkg.sv
package cfgsu_pkg;

  localparam int DATA_W  = 32;
  localparam int STRAP_W = 16;
  localparam int N_SLOT  = 5;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_BAD   = 2'd3
  } acc_size_e;

  localparam logic [DATA_W-1:0] PTR_WMASK = 32'h80FF_FFFC;

  // dword index of each implemented slot inside a device's space
  function automatic int slot_dword_index(input int s);
    return (s < 4) ? s : 64;
  endfunction

  function automatic logic [DATA_W-1:0] slot_wmask(input int s);
    case (s)
      1:       return 32'h0000_FFFF;
      2:       return 32'hFFFF_FFFF;
      3:       return 32'h0F0F_0F0F;
      4:       return 32'hFFFF_FF00;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slot_rmask(input int s);
    case (s)
      1:       return 32'h00FF_FFFF;
      3:       return 32'h3F3F_3F3F;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slot_default(input int d, input int s,
                                                     input logic [STRAP_W-1:0] strap);
    logic [DATA_W-1:0] v;
    case (s)
      0:       v = 32'hA5C0_3C3C | (DATA_W'(d) << 16);
      1:       v = (d == 0) ? {8'h00, strap[7:0], 16'h0000} : 32'h0011_0000;
      3:       v = 32'h1010_1010;
      4:       v = (d == 0) ? {24'h0, strap[15:8]} : 32'h0000_00AB;
      default: v = '0;
    endcase
    return v & slot_rmask(s);
  endfunction

endpackage

// File: rtl/cfgsu_decode.sv
module cfgsu_decode
  import cfgsu_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DEV_W     = 2,
  parameter int N_DEV     = 2,
  parameter int LOW_LIMIT = 256,
  localparam int DI_W     = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int SI_W     = $clog2(N_SLOT),
  localparam int DW_W     = ADDR_W - 2
) (
  input  logic              req_mmio,
  input  logic              req_ptr,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              deny,
  output logic              hit,
  output logic [DI_W-1:0]   dev_idx,
  output logic [SI_W-1:0]   slot_idx,
  output logic [3:0]        lane_be,
  output logic [1:0]        lane
);

  logic [N_SLOT-1:0] match;
  logic misalign, ext_bad, dev_ok;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_match
    assign match[s] = (req_addr[ADDR_W-1:2] == DW_W'(slot_dword_index(s)));
  end

  always_comb begin
    slot_idx = '0;
    for (int s = N_SLOT - 1; s >= 0; s--) begin
      if (match[s]) slot_idx = SI_W'(s);
    end
  end

  assign lane     = req_addr[1:0];
  assign misalign = (req_size == SZ_BAD) ||
                    ((req_size == SZ_WORD)  && req_addr[0]) ||
                    ((req_size == SZ_DWORD) && (req_addr[1:0] != 2'b00));
  assign ext_bad  = (int'(req_addr) >= LOW_LIMIT) && !(req_mmio && (req_size == SZ_DWORD));
  assign deny     = req_ptr ? (req_size != SZ_DWORD) : (misalign || ext_bad);
  assign dev_ok   = int'(req_dev) < N_DEV;
  assign dev_idx  = DI_W'(req_dev);
  assign hit      = !req_ptr && dev_ok && (|match);

  always_comb begin
    case (req_size)
      SZ_BYTE:  lane_be = 4'b0001 << lane;
      SZ_WORD:  lane_be = 4'b0011 << lane;
      SZ_DWORD: lane_be = 4'b1111;
      default:  lane_be = 4'b0000;
    endcase
  end

endmodule

// File: rtl/cfgsu_regbank.sv
module cfgsu_regbank
  import cfgsu_pkg::*;
#(
  parameter int N_DEV  = 2,
  localparam int DI_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int SI_W  = $clog2(N_SLOT),
  localparam int FLAT_W = N_DEV * N_SLOT * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wr_en,
  input  logic [DI_W-1:0]    dev_idx,
  input  logic [SI_W-1:0]    slot_idx,
  input  logic [3:0]         be,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rd_data
);

  logic [FLAT_W-1:0] flat;
  logic [DATA_W-1:0] be_bits;

  assign be_bits = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      localparam logic [DATA_W-1:0] WM = slot_wmask(s);
      logic [DATA_W-1:0] q;
      logic              sel;
      logic [DATA_W-1:0] m;

      assign sel = wr_en && (int'(dev_idx) == d) && (int'(slot_idx) == s);
      assign m   = WM & be_bits;

      always_ff @(posedge clk) begin
        if (rst)      q <= slot_default(d, s, strap_i);
        else if (sel) q <= (q & ~m) | (wdata & m);
      end

      assign flat[(d*N_SLOT+s)*DATA_W +: DATA_W] = q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int d = 0; d < N_DEV; d++) begin
      for (int s = 0; s < N_SLOT; s++) begin
        if ((int'(dev_idx) == d) && (int'(slot_idx) == s))
          rd_data = flat[(d*N_SLOT+s)*DATA_W +: DATA_W] & slot_rmask(s);
      end
    end
  end

endmodule

// File: rtl/cfg_space_unit.sv
module cfg_space_unit
  import cfgsu_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DEV_W     = 2,
  parameter int N_DEV     = 2,
  parameter int LOW_LIMIT = 256,
  localparam int DI_W     = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int SI_W     = $clog2(N_SLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       strap_i,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_mmio,
  input  logic              req_ptr,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);

  logic              deny, hit;
  logic [DI_W-1:0]   dev_idx;
  logic [SI_W-1:0]   slot_idx;
  logic [3:0]        lane_be;
  logic [1:0]        lane;
  logic [DATA_W-1:0] wdata_sh, bank_rd, rd_sh, size_mask, rd_val;
  logic [DATA_W-1:0] ptr_q;
  logic              wr_en, ptr_wr;

  cfgsu_decode #(
    .ADDR_W(ADDR_W), .DEV_W(DEV_W), .N_DEV(N_DEV), .LOW_LIMIT(LOW_LIMIT)
  ) dec_i (
    .req_mmio(req_mmio), .req_ptr(req_ptr), .req_dev(req_dev),
    .req_addr(req_addr), .req_size(req_size),
    .deny(deny), .hit(hit), .dev_idx(dev_idx), .slot_idx(slot_idx),
    .lane_be(lane_be), .lane(lane)
  );

  assign wdata_sh = req_wdata << {lane, 3'b000};
  assign wr_en    = req_valid && req_write && !deny && hit;

  cfgsu_regbank #(.N_DEV(N_DEV)) bank_i (
    .clk(clk), .rst(rst), .strap_i(strap_i), .wr_en(wr_en),
    .dev_idx(dev_idx), .slot_idx(slot_idx), .be(lane_be),
    .wdata(wdata_sh), .rd_data(bank_rd)
  );

  // configuration-address pointer: dword-only
  assign ptr_wr = req_valid && req_write && req_ptr && !deny;

  always_ff @(posedge clk) begin
    if (rst)         ptr_q <= '0;
    else if (ptr_wr) ptr_q <= req_wdata & PTR_WMASK;
  end

  assign rd_sh = bank_rd >> {lane, 3'b000};

  always_comb begin
    case (req_size)
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_WORD: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
    if (req_ptr)  rd_val = ptr_q;
    else if (hit) rd_val = rd_sh & size_mask;
    else          rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && deny;
      if (!req_valid)     rsp_rdata <= '0;
      else if (deny)      rsp_rdata <= '1;
      else if (req_write) rsp_rdata <= '0;
      else                rsp_rdata <= rd_val;
    end
  end

endmodule

// File: rtl/cfgsu_checker.sv
module cfgsu_checker #(
  parameter int ADDR_W    = 12,
  parameter int DEV_W     = 2,
  parameter int LOW_LIMIT = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_mmio,
  input logic              req_ptr,
  input logic [DEV_W-1:0]  req_dev,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic [31:0]       ptr_q
);

  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_stray_rsp_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_misaligned_refused_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ptr && ((req_size == 2'd3) ||
      (req_size == 2'd1 && req_addr[0]) ||
      (req_size == 2'd2 && req_addr[1:0] != 2'b00))) |=> rsp_err);

  assert_ext_path_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ptr && (int'(req_addr) >= LOW_LIMIT) && !req_mmio) |=> rsp_err);

  assert_err_data_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && (rsp_rdata == 32'hFFFF_FFFF)));

  assert_ptr_narrow_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ptr && req_size != 2'd2) |=> (rsp_err && $stable(ptr_q)));

  assert_ptr_reserved_R6: assert property (@(posedge clk) disable iff (rst)
    (ptr_q & 32'h7F00_0003) == 32'h0);

  assert_write_rdata_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (rsp_err || rsp_rdata == 32'h0));

  logic unused_ok;
  assign unused_ok = ^req_dev;

endmodule

bind cfg_space_unit cfgsu_checker #(
  .ADDR_W(ADDR_W), .DEV_W(DEV_W), .LOW_LIMIT(LOW_LIMIT)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_mmio(req_mmio), .req_ptr(req_ptr), .req_dev(req_dev),
  .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .ptr_q(ptr_q)
);

// File: tb/cfg_space_unit_tb_top.sv
module cfg_space_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] strap_i = 16'h0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_mmio = 1'b0, req_ptr = 1'b0;
  logic [1:0]  req_dev = '0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_space_unit dut_i (
    .clk(clk), .rst(rst), .strap_i(strap_i), .req_valid(req_valid),
    .req_write(req_write), .req_mmio(req_mmio), .req_ptr(req_ptr),
    .req_dev(req_dev), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err)
  );

  // reference model built from the register map
  logic [31:0] mm [0:1][0:4];
  logic [31:0] ptr_m;

  function automatic logic [31:0] m_wm(int s);
    logic [31:0] t [0:4] = '{32'h0, 32'h0000FFFF, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'hFFFFFF00};
    return t[s];
  endfunction

  function automatic logic [31:0] m_rm(int s);
    logic [31:0] t [0:4] = '{32'hFFFFFFFF, 32'h00FFFFFF, 32'hFFFFFFFF, 32'h3F3F3F3F, 32'hFFFFFFFF};
    return t[s];
  endfunction

  function automatic int m_slot(int a);
    if (a < 16) return a / 4;
    if (a >= 256 && a < 260) return 4;
    return -1;
  endfunction

  function automatic bit m_err(bit mmio, bit ptr, int a, int sz);
    if (ptr) return sz != 2;
    if (sz == 3) return 1;
    if (sz == 1 && (a % 2) != 0) return 1;
    if (sz == 2 && (a % 4) != 0) return 1;
    if (a >= 256 && !(mmio && sz == 2)) return 1;
    return 0;
  endfunction

  task automatic model_reset(input logic [15:0] st);
    for (int d = 0; d < 2; d++) begin
      mm[d][0] = 32'hA5C03C3C + (d << 16);
      mm[d][1] = (d == 0) ? {8'h00, st[7:0], 16'h0} : 32'h00110000;
      mm[d][2] = 32'h0;
      mm[d][3] = 32'h10101010;
      mm[d][4] = (d == 0) ? {24'h0, st[15:8]} : 32'h000000AB;
    end
    ptr_m = 32'h0;
  endtask

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input bit mmio, input bit ptr, input int dev,
                     input int a, input int sz, input logic [31:0] wd,
                     output logic [31:0] got);
    bit          e;
    int          s, ln;
    logic [31:0] exp, be, smask;
    string       tag;
    e  = m_err(mmio, ptr, a, sz);
    s  = (dev < 2) ? m_slot(a) : -1;
    ln = a % 4;
    smask = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFFFFFF;
    if (e) begin
      exp = 32'hFFFFFFFF;
      tag = ptr ? "R6 ptr refused" : (a >= 256 ? "R4/R5 refused" : "R3/R5 refused");
    end else if (wr) begin
      exp = 32'h0;
      tag = ptr ? "R6 ptr write" : (s < 0 ? "R7 reserved write" : "R1 write rsp");
    end else if (ptr) begin
      exp = ptr_m; tag = "R6 ptr read";
    end else if (s < 0) begin
      exp = 32'h0; tag = "R7 reserved read";
    end else begin
      exp = ((mm[dev][s] & m_rm(s)) >> (8 * ln)) & smask; tag = "R2 read";
    end
    if (wr && !e) begin
      if (ptr) ptr_m = wd & 32'h80FFFFFC;
      else if (s >= 0) begin
        be = (smask << (8 * ln)) & m_wm(s);
        mm[dev][s] = (mm[dev][s] & ~be) | ((wd << (8 * ln)) & be);
      end
    end
    @(negedge clk);
    req_valid = 1; req_write = wr; req_mmio = mmio; req_ptr = ptr;
    req_dev = dev[1:0]; req_addr = a[11:0]; req_size = sz[1:0]; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    got = rsp_rdata;
    check($sformatf("%s dev=%0d a=%h sz=%0d wr=%0d", tag, dev, a, sz, wr),
          {rsp_valid, rsp_err, rsp_rdata}, {1'b1, e, exp});
  endtask

  task automatic do_reset(input logic [15:0] st);
    @(negedge clk);
    req_valid = 0; rst = 1; strap_i = st;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset(st);
    @(negedge clk);
    check("R1 reset state", {rsp_valid, rsp_err, rsp_rdata}, 34'h0);
  endtask

  task automatic sweep_low();
    logic [31:0] g;
    for (int d = 0; d < 4; d++)
      for (int a = 0; a < 20; a++)
        for (int sz = 0; sz < 4; sz++)
          acc(0, a[0], 0, d, a, sz, 32'h0, g);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] g;
    do_reset(16'h5AC3);
    acc(0, 0, 0, 0, 4, 2, 0, g);
    check("R10 strap into control", {2'b0, g}, {2'b0, 32'h00C30000});
    acc(0, 1, 0, 0, 256, 2, 0, g);
    check("R10 strap into extended", {2'b0, g}, {2'b0, 32'h0000005A});
    acc(0, 0, 0, 1, 0, 2, 0, g);
    check("R11 link set identity", {2'b0, g}, {2'b0, 32'hA5C13C3C});

    sweep_low();
    for (int d = 0; d < 4; d++)
      for (int a = 252; a < 264; a++)
        for (int m = 0; m < 2; m++)
          for (int sz = 0; sz < 4; sz++)
            acc(0, m[0], 0, d, a, sz, 0, g);
    acc(0, 1, 0, 0, 512, 2, 0, g);

    // full-width writes then sweep (R8, R11)
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 5; s++)
        acc(1, 1, 0, d, (s < 4) ? 4 * s : 256, 2, 32'hFFFFFFFF, g);
    acc(0, 0, 0, 0, 12, 2, 0, g);
    check("R9 mixed reserved bits zero", {2'b0, g}, {2'b0, 32'h1F1F1F1F});
    sweep_low();

    // byte and word lane writes (R8)
    for (int d = 0; d < 2; d++) begin
      for (int a = 0; a < 16; a++)
        acc(1, 0, 0, d, a, 0, (a * 7 + 3 + d * 64) & 8'hFF, g);
      for (int a = 0; a < 16; a += 2)
        if ((a % 4) == 2) acc(1, 0, 0, d, a, 1, 32'h0000C35A ^ a, g);
    end
    sweep_low();
    acc(0, 0, 0, 1, 8, 2, 0, g);
    check("R11 link scratch separate", {2'b0, g}, {2'b0, mm[1][2]});

    // refused writes leave targets unchanged (R5)
    acc(1, 0, 0, 0, 9, 1, 32'h1111, g);
    acc(1, 0, 0, 0, 10, 2, 32'h22222222, g);
    acc(1, 0, 0, 0, 8, 3, 32'h33333333, g);
    acc(1, 0, 0, 0, 256, 2, 32'h44444444, g);
    acc(1, 1, 0, 0, 256, 0, 32'h55, g);
    acc(1, 1, 0, 1, 258, 1, 32'h6666, g);
    acc(0, 0, 0, 0, 8, 2, 0, g);
    acc(0, 1, 0, 0, 256, 2, 0, g);
    acc(0, 1, 0, 1, 256, 2, 0, g);

    // reserved locations (R7)
    acc(1, 0, 0, 1, 64, 2, 32'hDEADBEEF, g);
    acc(0, 0, 0, 1, 64, 2, 0, g);
    acc(1, 1, 0, 3, 8, 2, 32'hDEADBEEF, g);
    acc(0, 1, 0, 3, 8, 2, 0, g);

    // pointer register (R6)
    acc(0, 0, 1, 0, 0, 2, 0, g);
    acc(1, 0, 1, 2, 5, 2, 32'hFFFFFFFF, g);
    acc(0, 0, 1, 0, 0, 2, 0, g);
    check("R6 pointer writable mask", {2'b0, g}, {2'b0, 32'h80FFFFFC});
    acc(1, 0, 1, 0, 0, 0, 32'h0, g);
    acc(1, 0, 1, 0, 0, 1, 32'h0, g);
    acc(0, 0, 1, 0, 0, 0, 0, g);
    acc(1, 0, 1, 0, 0, 2, 32'h12345678, g);
    acc(0, 1, 1, 3, 256, 2, 0, g);

    // second reset with different straps (R10)
    do_reset(16'h1234);
    acc(0, 0, 0, 0, 6, 0, 0, g);
    check("R10 strap byte after reset", {2'b0, g}, {2'b0, 32'h34});
    acc(0, 1, 0, 0, 256, 2, 0, g);
    check("R10 ext after reset", {2'b0, g}, {2'b0, 32'h12});
    acc(0, 0, 1, 0, 0, 2, 0, g);
    acc(0, 0, 0, 1, 12, 2, 0, g);
    sweep_low();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule